// File: doc/BRIEF.md
# Segment Descriptor Load and Check Unit

This block holds one cached segment register on a protected-mode address path. A load request presents a 64-bit segment descriptor together with the current privilege level and a requested privilege level. The unit unpacks base, limit and the attribute byte, and checks three things in a fixed order: that the segment is present, that it is a code or data segment, and that the privilege rules allow the load. When every check passes, it caches the segment. In the same cycle it raises a one-cycle write-back request that carries the descriptor with its accessed flag set, so that the descriptor table in memory can be updated.

After a segment is loaded, each access presents an offset and a kind: read, write or execute. The unit checks the kind against the cached type bits and the offset against the cached limit. The limit test is reversed for expand-down data segments. One cycle after the request, the unit returns either the linear address (base plus offset) or a fault code. Table walking, gates, task switching, paging and granularity scaling are handled elsewhere.

Top module: `seg_unit`

## Requirements
- R1: Descriptor fields are taken from fixed bit positions. The base is bits 63:56 over bits 39:16. The limit is bits 51:48 over bits 15:0, in bytes. The attribute byte is bits 47:40: present at 47, privilege at 46:45, class (1 = code/data) at 44, executable at 43, direction/conforming at 42, write/read enable at 41 and accessed at 40.
- R2: A load reports its result on `ld_done` exactly one cycle after `ld_req`, with `ld_fault`. Fault codes are 0 none, 1 absent, 2 privilege, 3 type and 4 limit. When no load was requested in the previous cycle, `ld_fault` reads 0.
- R3: A load whose present bit is 0 faults with code 1. Any failed load leaves the cached segment (`seg_valid`, base, limit, type) unchanged.
- R4: A present descriptor with class bit 0 (a system or gate descriptor) faults with code 3.
- R5: For data segments and non-conforming code segments, a load faults with code 2 when the larger of `cpl` and `ld_rpl` is numerically above the descriptor privilege. Conforming code segments (executable=1, conforming=1) skip this check.
- R6: A successful load raises `wb_req` for exactly one cycle, aligned with `ld_done`. `wb_data` equals the loaded descriptor with bit 40 set. A failed load does not raise `wb_req`.
- R7: Access kind encoding is 0 read, 1 write, 2 execute, and 3 is reserved. For a data segment, a write with the write-enable bit at 0 faults with code 3, and execute faults with code 3. For a code segment, a read with the read-enable bit at 0 faults with code 3, and a write always faults with code 3. Kind 3 always faults with code 3. The type check takes priority over the limit check.
- R8: For expand-up segments, an offset is valid when it is at most the limit. For expand-down data segments (executable=0, direction=1), an offset is valid only when it is strictly greater than the limit. Other offsets fault with code 4.
- R9: An access reports on `acc_valid` exactly one cycle after `acc_req`. It returns `acc_fault`, and `acc_lin` equals base plus offset modulo 2^32 when the fault is 0. `acc_lin` reads 0 otherwise.
- R10: An access made while no segment has been loaded since reset faults with code 1. An access in the same cycle as a load uses the segment cached before that load.
- R11: Synchronous active-high reset clears `seg_valid`, `ld_done`, `wb_req` and `acc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Load request |
| ld_desc | input | 64 | Descriptor to load |
| ld_rpl | input | 2 | Requested privilege level |
| cpl | input | 2 | Current privilege level |
| ld_done | output | 1 | Load result valid |
| ld_fault | output | 3 | Load fault code |
| wb_req | output | 1 | Accessed-flag write-back request |
| wb_data | output | 64 | Descriptor to write back |
| seg_valid | output | 1 | A segment is cached |
| acc_req | input | 1 | Access request |
| acc_off | input | OFF_W | Access offset |
| acc_kind | input | 2 | Access kind |
| acc_valid | output | 1 | Access result valid |
| acc_fault | output | 3 | Access fault code |
| acc_lin | output | 32 | Linear address |

## Verification
The bench builds the unit with its default offset width of 32 bits, the same width as the base. With that width, offsets above the 20-bit limit can be driven. This makes both sides of the expand-down boundary and the case where base plus offset wraps past 2^32 reachable. A narrower offset width would select the other generate branch, where the limit compare needs no zero extension, and the bench does not build that variant.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int DESC_W  = 64;
  localparam int BASE_W  = 32;
  localparam int LIM_W   = 20;
  localparam int PL_W    = 2;
  localparam int ACC_BIT = 40;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_PRIV   = 3'd2,
    FLT_TYPE   = 3'd3,
    FLT_LIMIT  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef struct packed {
    logic            present;
    logic [PL_W-1:0] dpl;
    logic            seg_cls;
    logic            exec;
    logic            dir_conf;
    logic            rw_en;
  } attr_t;

  typedef struct packed {
    logic exec;
    logic dir_conf;
    logic rw_en;
  } seg_type_t;
endpackage

// File: rtl/seg_desc_fields.sv
module seg_desc_fields
  import seg_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output logic [BASE_W-1:0] base,
  output logic [LIM_W-1:0]  limit,
  output attr_t             attr
);
  logic [4:0] unused_bits;

  assign base  = {desc[63:56], desc[39:16]};
  assign limit = {desc[51:48], desc[15:0]};
  assign attr  = '{present:  desc[47],
                   dpl:      desc[46:45],
                   seg_cls:  desc[44],
                   exec:     desc[43],
                   dir_conf: desc[42],
                   rw_en:    desc[41]};
  assign unused_bits = {desc[55:52], desc[ACC_BIT]};
endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_req,
  input  logic [DESC_W-1:0] ld_desc,
  input  logic [PL_W-1:0]   ld_rpl,
  input  logic [PL_W-1:0]   cpl,
  input  logic [BASE_W-1:0] dec_base,
  input  logic [LIM_W-1:0]  dec_limit,
  input  attr_t             dec_attr,
  output logic              ld_done,
  output fault_e            ld_fault,
  output logic              wb_req,
  output logic [DESC_W-1:0] wb_data,
  output logic              seg_valid,
  output logic [BASE_W-1:0] c_base,
  output logic [LIM_W-1:0]  c_limit,
  output seg_type_t         c_type
);
  localparam logic [DESC_W-1:0] ACC_MASK = DESC_W'(1) << ACC_BIT;

  logic [PL_W-1:0] eff_pl;
  logic            conforming;
  fault_e          verdict;

  assign eff_pl     = (cpl > ld_rpl) ? cpl : ld_rpl;
  assign conforming = dec_attr.exec && dec_attr.dir_conf;

  always_comb begin
    if (!dec_attr.present)                      verdict = FLT_ABSENT;
    else if (!dec_attr.seg_cls)                 verdict = FLT_TYPE;
    else if (!conforming && eff_pl > dec_attr.dpl) verdict = FLT_PRIV;
    else                                        verdict = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_done   <= 1'b0;
      ld_fault  <= FLT_NONE;
      wb_req    <= 1'b0;
      wb_data   <= '0;
      seg_valid <= 1'b0;
      c_base    <= '0;
      c_limit   <= '0;
      c_type    <= '0;
    end else begin
      ld_done  <= ld_req;
      ld_fault <= ld_req ? verdict : FLT_NONE;
      wb_req   <= ld_req && (verdict == FLT_NONE);
      if (ld_req && verdict == FLT_NONE) begin
        wb_data   <= ld_desc | ACC_MASK;
        seg_valid <= 1'b1;
        c_base    <= dec_base;
        c_limit   <= dec_limit;
        c_type    <= '{exec: dec_attr.exec, dir_conf: dec_attr.dir_conf,
                       rw_en: dec_attr.rw_en};
      end
    end
  end
endmodule

// File: rtl/seg_access_path.sv
module seg_access_path
  import seg_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_req,
  input  logic [OFF_W-1:0]  acc_off,
  input  kind_e             acc_kind,
  input  logic              seg_valid,
  input  logic [BASE_W-1:0] c_base,
  input  logic [LIM_W-1:0]  c_limit,
  input  seg_type_t         c_type,
  output logic              acc_valid,
  output fault_e            acc_fault,
  output logic [BASE_W-1:0] acc_lin
);
  logic [OFF_W-1:0] lim_ext;
  logic             type_bad;
  logic             in_range;
  logic             exp_down;
  fault_e           verdict;

  generate
    if (OFF_W > LIM_W) begin : g_pad
      assign lim_ext = {{(OFF_W-LIM_W){1'b0}}, c_limit};
    end else begin : g_same
      assign lim_ext = c_limit[OFF_W-1:0];
    end
  endgenerate

  assign exp_down = !c_type.exec && c_type.dir_conf;
  assign in_range = exp_down ? (acc_off > lim_ext) : (acc_off <= lim_ext);

  always_comb begin
    case (acc_kind)
      KIND_READ:  type_bad = c_type.exec && !c_type.rw_en;
      KIND_WRITE: type_bad = c_type.exec || !c_type.rw_en;
      KIND_EXEC:  type_bad = !c_type.exec;
      default:    type_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (!seg_valid)     verdict = FLT_ABSENT;
    else if (type_bad)  verdict = FLT_TYPE;
    else if (!in_range) verdict = FLT_LIMIT;
    else                verdict = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_fault <= FLT_NONE;
      acc_lin   <= '0;
    end else begin
      acc_valid <= acc_req;
      acc_fault <= acc_req ? verdict : FLT_NONE;
      acc_lin   <= (acc_req && verdict == FLT_NONE)
                   ? c_base + BASE_W'(acc_off) : '0;
    end
  end
endmodule

// File: rtl/seg_unit.sv
module seg_unit
  import seg_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_req,
  input  logic [63:0]       ld_desc,
  input  logic [1:0]        ld_rpl,
  input  logic [1:0]        cpl,
  output logic              ld_done,
  output logic [2:0]        ld_fault,
  output logic              wb_req,
  output logic [63:0]       wb_data,
  output logic              seg_valid,
  input  logic              acc_req,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [1:0]        acc_kind,
  output logic              acc_valid,
  output logic [2:0]        acc_fault,
  output logic [31:0]       acc_lin
);
  logic [BASE_W-1:0] dec_base, c_base;
  logic [LIM_W-1:0]  dec_limit, c_limit;
  attr_t             dec_attr;
  seg_type_t         c_type;
  fault_e            ld_f, acc_f;

  seg_desc_fields u_dec (
    .desc  (ld_desc),
    .base  (dec_base),
    .limit (dec_limit),
    .attr  (dec_attr)
  );

  seg_load_ctrl u_load (
    .clk       (clk),
    .rst       (rst),
    .ld_req    (ld_req),
    .ld_desc   (ld_desc),
    .ld_rpl    (ld_rpl),
    .cpl       (cpl),
    .dec_base  (dec_base),
    .dec_limit (dec_limit),
    .dec_attr  (dec_attr),
    .ld_done   (ld_done),
    .ld_fault  (ld_f),
    .wb_req    (wb_req),
    .wb_data   (wb_data),
    .seg_valid (seg_valid),
    .c_base    (c_base),
    .c_limit   (c_limit),
    .c_type    (c_type)
  );

  seg_access_path #(.OFF_W(OFF_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .acc_req   (acc_req),
    .acc_off   (acc_off),
    .acc_kind  (kind_e'(acc_kind)),
    .seg_valid (seg_valid),
    .c_base    (c_base),
    .c_limit   (c_limit),
    .c_type    (c_type),
    .acc_valid (acc_valid),
    .acc_fault (acc_f),
    .acc_lin   (acc_lin)
  );

  assign ld_fault  = ld_f;
  assign acc_fault = acc_f;
endmodule

// File: rtl/seg_unit_checks.sv
module seg_unit_checks (
  input logic        clk,
  input logic        rst,
  input logic        ld_req,
  input logic [63:0] ld_desc,
  input logic        ld_done,
  input logic [2:0]  ld_fault,
  input logic        wb_req,
  input logic [63:0] wb_data,
  input logic        seg_valid,
  input logic        acc_req,
  input logic        acc_valid,
  input logic [2:0]  acc_fault,
  input logic [31:0] acc_lin
);
  a_r2_done_after_req: assert property (@(posedge clk) disable iff (rst)
    ld_done |-> $past(ld_req));
  a_r2_quiet_fault: assert property (@(posedge clk) disable iff (rst)
    !ld_done |-> ld_fault == 3'd0);
  a_r3_fail_keeps_valid: assert property (@(posedge clk) disable iff (rst)
    (ld_done && ld_fault != 3'd0) |-> seg_valid == $past(seg_valid));
  a_r6_wb_only_on_success: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> (ld_done && ld_fault == 3'd0 && seg_valid));
  a_r6_wb_sets_accessed: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> (wb_data == ($past(ld_desc) | 64'h0000_0100_0000_0000)));
  a_r9_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $past(acc_req));
  a_r9_lin_zero_on_fault: assert property (@(posedge clk) disable iff (rst)
    (acc_fault != 3'd0) |-> (acc_valid && acc_lin == 32'd0));
  a_r10_absent_without_seg: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !$past(seg_valid)) |-> acc_fault == 3'd1);
endmodule

bind seg_unit seg_unit_checks u_checks (
  .clk       (clk),
  .rst       (rst),
  .ld_req    (ld_req),
  .ld_desc   (ld_desc),
  .ld_done   (ld_done),
  .ld_fault  (ld_fault),
  .wb_req    (wb_req),
  .wb_data   (wb_data),
  .seg_valid (seg_valid),
  .acc_req   (acc_req),
  .acc_valid (acc_valid),
  .acc_fault (acc_fault),
  .acc_lin   (acc_lin)
);

// File: tb/seg_unit_test.sv
`timescale 1ns/1ps
module seg_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_req = 1'b0;
  logic [63:0] ld_desc = '0;
  logic [1:0]  ld_rpl = '0;
  logic [1:0]  cpl = '0;
  logic        ld_done, wb_req, seg_valid, acc_valid;
  logic [2:0]  ld_fault, acc_fault;
  logic [63:0] wb_data;
  logic        acc_req = 1'b0;
  logic [31:0] acc_off = '0;
  logic [1:0]  acc_kind = '0;
  logic [31:0] acc_lin;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  seg_unit uut (.*);

  function automatic logic [7:0] abyte(input bit p, input bit [1:0] dpl, input bit cls,
                                       input bit ex, input bit dc, input bit rw);
    return {p, dpl, cls, ex, dc, rw, 1'b0};
  endfunction

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                     input logic [7:0] ab);
    return {base[31:24], 4'h0, lim[19:16], ab, base[23:0], lim[15:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input string req, input logic [63:0] d, input logic [1:0] rpl,
                         input logic [1:0] cp, input logic [2:0] exp_f);
    @(negedge clk);
    ld_req = 1'b1; ld_desc = d; ld_rpl = rpl; cpl = cp;
    @(posedge clk); #1;
    ld_req = 1'b0;
    chk(req, "ld_done", 64'(ld_done), 64'd1);
    chk(req, "ld_fault", 64'(ld_fault), 64'(exp_f));
    chk(req, "wb_req", 64'(wb_req), 64'(exp_f == 3'd0));
    if (exp_f == 3'd0) chk("R6", "wb_data", wb_data, d | (64'd1 << 40));
  endtask

  task automatic do_acc(input string req, input logic [31:0] off, input logic [1:0] kind,
                        input logic [2:0] exp_f, input logic [31:0] exp_lin);
    @(negedge clk);
    acc_req = 1'b1; acc_off = off; acc_kind = kind;
    @(posedge clk); #1;
    acc_req = 1'b0;
    chk(req, "acc_valid", 64'(acc_valid), 64'd1);
    chk(req, "acc_fault", 64'(acc_fault), 64'(exp_f));
    chk(req, "acc_lin", 64'(acc_lin), 64'(exp_lin));
  endtask

  task automatic t_reset;
    chk("R11", "seg_valid", 64'(seg_valid), 64'd0);
    chk("R11", "ld_done", 64'(ld_done), 64'd0);
    chk("R11", "wb_req", 64'(wb_req), 64'd0);
    chk("R11", "acc_valid", 64'(acc_valid), 64'd0);
    do_acc("R10", 32'h10, 2'd0, 3'd1, 32'd0);
  endtask

  task automatic t_data_rw;
    logic [63:0] d = mk(32'h1234_5000, 20'h00FFF, abyte(1, 3, 1, 0, 0, 1));
    do_load("R1", d, 2'd0, 2'd0, 3'd0);
    chk("R3", "seg_valid", 64'(seg_valid), 64'd1);
    @(posedge clk); #1;
    chk("R6", "wb_req one cycle", 64'(wb_req), 64'd0);
    chk("R2", "ld_fault idle", 64'(ld_fault), 64'd0);
    do_acc("R9", 32'h10, 2'd0, 3'd0, 32'h1234_5010);
    do_acc("R8", 32'h0FFF, 2'd1, 3'd0, 32'h1234_5FFF);
    do_acc("R8", 32'h1000, 2'd0, 3'd4, 32'd0);
    do_acc("R7", 32'h10, 2'd2, 3'd3, 32'd0);
    do_acc("R7", 32'h10, 2'd3, 3'd3, 32'd0);
    do_acc("R7", 32'h2000, 2'd2, 3'd3, 32'd0);
  endtask

  task automatic t_failed_loads;
    do_load("R3", mk(32'hAAAA_0000, 20'hFFFFF, abyte(0, 3, 1, 0, 0, 1)), 2'd0, 2'd0, 3'd1);
    do_acc("R3", 32'h20, 2'd0, 3'd0, 32'h1234_5020);
    do_load("R4", mk(32'hBBBB_0000, 20'hFFFFF, abyte(1, 3, 0, 0, 1, 0)), 2'd0, 2'd0, 3'd3);
    do_load("R5", mk(32'hCCCC_0000, 20'hFFFFF, abyte(1, 0, 1, 0, 0, 1)), 2'd0, 2'd3, 3'd2);
    do_load("R5", mk(32'hCCCC_0000, 20'hFFFFF, abyte(1, 2, 1, 0, 0, 1)), 2'd3, 2'd1, 3'd2);
    do_load("R5", mk(32'hCCCC_0000, 20'hFFFFF, abyte(1, 0, 1, 1, 0, 1)), 2'd0, 2'd3, 3'd2);
    do_acc("R3", 32'h30, 2'd1, 3'd0, 32'h1234_5030);
  endtask

  task automatic t_readonly;
    do_load("R5", mk(32'h0004_0000, 20'h000FF, abyte(1, 2, 1, 0, 0, 0)), 2'd2, 2'd1, 3'd0);
    do_acc("R7", 32'h8, 2'd1, 3'd3, 32'd0);
    do_acc("R7", 32'h8, 2'd0, 3'd0, 32'h0004_0008);
    do_acc("R7", 32'h1000, 2'd1, 3'd3, 32'd0);
  endtask

  task automatic t_code;
    do_load("R5", mk(32'h0010_0000, 20'h0FFFF, abyte(1, 0, 1, 1, 1, 0)), 2'd3, 2'd3, 3'd0);
    do_acc("R7", 32'h40, 2'd2, 3'd0, 32'h0010_0040);
    do_acc("R7", 32'h40, 2'd0, 3'd3, 32'd0);
    do_acc("R7", 32'h40, 2'd1, 3'd3, 32'd0);
    do_acc("R8", 32'h10000, 2'd2, 3'd4, 32'd0);
    do_load("R7", mk(32'h0020_0000, 20'h0FFFF, abyte(1, 3, 1, 1, 0, 1)), 2'd0, 2'd0, 3'd0);
    do_acc("R7", 32'h44, 2'd0, 3'd0, 32'h0020_0044);
    do_acc("R7", 32'h44, 2'd1, 3'd3, 32'd0);
  endtask

  task automatic t_expand_down;
    do_load("R8", mk(32'h0800_0000, 20'h00FFF, abyte(1, 3, 1, 0, 1, 1)), 2'd0, 2'd0, 3'd0);
    do_acc("R8", 32'h0FFF, 2'd0, 3'd4, 32'd0);
    do_acc("R8", 32'h0, 2'd1, 3'd4, 32'd0);
    do_acc("R8", 32'h1000, 2'd1, 3'd0, 32'h0800_1000);
    do_acc("R8", 32'hFFFF_FFF0, 2'd0, 3'd0, 32'h07FF_FFF0);
  endtask

  task automatic t_wrap_and_overlap;
    do_load("R9", mk(32'hFFFF_F000, 20'hFFFFF, abyte(1, 3, 1, 0, 0, 1)), 2'd0, 2'd0, 3'd0);
    do_acc("R9", 32'h2000, 2'd0, 3'd0, 32'h0000_1000);
    @(negedge clk);
    ld_req = 1'b1; ld_desc = mk(32'h0050_0000, 20'h00FFF, abyte(1, 3, 1, 0, 0, 1));
    ld_rpl = 2'd0; cpl = 2'd0;
    acc_req = 1'b1; acc_off = 32'h10; acc_kind = 2'd0;
    @(posedge clk); #1;
    ld_req = 1'b0; acc_req = 1'b0;
    chk("R10", "same-cycle lin", 64'(acc_lin), 64'h0000_0000_FFFF_F010);
    do_acc("R10", 32'h10, 2'd0, 3'd0, 32'h0050_0010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_data_rw();
    t_failed_loads();
    t_readonly();
    t_code();
    t_expand_down();
    t_wrap_and_overlap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule